// File: doc/BRIEF.md
# MDIO Management Master

This block is a Clause 22 management master that software drives through three registers: a command register, a write-data register and a status register. Software writes the address fields, opcode, start and turnaround codes and a clock divider into the command register. It then writes the command again with the launch bit set. The block shifts a 64-bit management frame out on the serial clock and data pins, shows busy while it runs, and collects 16 bits of read data from the PHY.

A frame starts only when a write moves the launch bit from 0 to 1. A launch bit that stays high starts nothing, so software must clear it before the next command. A soft-reset bit in the command register halts any frame and keeps the controller idle while it is set. The divider value survives that reset.

Top module: `mdio_master`

## Requirements
- R1: After rst_ni, the command register reads 0x0070000 (divider field = 7, every other field 0). The status and write-data registers read 0. mdc_o and mdio_oe_o are low.
- R2: Register offsets are 0 for command, 1 for write data ([15:0]) and 2 for status ([15:0] read data, [16] busy). Command register fields: [4:0] PHY address, [9:5] register address, [11:10] opcode, [13:12] start code, [15:14] turnaround code, [23:16] divider, [24] launch, [25] soft reset. A command write that takes launch from 0 to 1 sets busy, and busy reads 1 in the cycle after that write. A command write with launch at 0 leaves busy at 0.
- R3: A command write with launch at 1 while the stored launch bit is already 1 starts no frame.
- R4: A launch edge written while busy is ignored. The current frame still has exactly 64 bits, and no second frame follows.
- R5: The frame is 32 ones, then start code, opcode, PHY address, register address, turnaround code and 16 data bits, each MSB first. For opcode 01 the data bits come from the write-data register.
- R6: mdc_o is low when idle and has a period of 2*(divider+1) clock cycles. mdio_o changes only when mdc_o falls, so the value at each rising edge is the frame bit.
- R7: For opcode 10 (read), mdio_oe_o is high for bits 0..46 and low from the second turnaround bit (bit 47) to the end. For any other opcode it is high for all 64 bits.
- R8: On a read, mdio_i is sampled at the rising MDC edges of bits 48..63 and stored MSB first. The result is in status[15:0] once busy reads 0.
- R9: Busy falls on the MDC falling edge that ends bit 63, after exactly 64 rising edges.
- R10: A command write with soft reset (bit 25) set stops the frame. In the next cycle busy, mdc_o and mdio_oe_o read 0. No launch is accepted while the bit is set, and the divider field keeps its written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register offset |
| reg_wdata_i | input | 26 | Register write data |
| reg_rdata_o | output | 26 | Register read data (combinational on reg_addr_i) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
A wrong bit index or a bad shift-register load shows up at the first MDC rising edge that carries the wrong frame bit. The bench compares every one of the 64 rising-edge samples against a frame it builds from the programmed fields. A faulty divider count shows up within two MDC edges as a period mismatch. A faulty launch-edge detector shows up one cycle after the command write, either as a busy flag that is missing or as busy raised on a level that stayed high. A stuck or early busy shows up as a wrong count of MDC edges when busy clears. A sampling error on reads shows up as a wrong value in status bits 15..0.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned DIV_W     = 8;
  localparam int unsigned PRE_LEN   = 32;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned HDR_W     = 16;
  localparam int unsigned FRAME_LEN = PRE_LEN + HDR_W + DATA_W;
  localparam int unsigned IDX_W     = $clog2(FRAME_LEN);

  localparam logic [1:0] OP_RD   = 2'b10;
  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_WDATA = 2'd1;
  localparam logic [1:0] A_STAT  = 2'd2;

  typedef struct packed {
    logic             srst;
    logic             load;
    logic [DIV_W-1:0] div;
    logic [1:0]       ta;
    logic [1:0]       st;
    logic [1:0]       op;
    logic [4:0]       reg_a;
    logic [4:0]       phy;
  } ctrl_t;

  localparam int unsigned REG_W = $bits(ctrl_t);

  typedef struct packed {
    logic [1:0] st;
    logic [1:0] op;
    logic [4:0] phy;
    logic [4:0] reg_a;
    logic [1:0] ta;
  } hdr_t;
endpackage

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter logic [DIV_W-1:0] DIV_RST = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DIV_W-1:0]  div_o,
  output logic [DATA_W-1:0] wr_data_o,
  output hdr_t              hdr_o,
  output logic              launch_o,
  output logic              srst_o
);
  ctrl_t             ctrl_q, new_c;
  logic [DATA_W-1:0] wd_q;
  logic              wr_ctrl;

  assign new_c    = ctrl_t'(wdata_i);
  assign wr_ctrl  = we_i && (addr_i == A_CTRL);
  assign srst_o   = ctrl_q.srst | (wr_ctrl & new_c.srst);
  // edge taken against the stored bit at the write itself
  assign launch_o = wr_ctrl & new_c.load & ~ctrl_q.load & ~busy_i & ~srst_o;

  assign hdr_o     = '{st: new_c.st, op: new_c.op, phy: new_c.phy,
                       reg_a: new_c.reg_a, ta: new_c.ta};
  assign div_o     = ctrl_q.div;
  assign wr_data_o = wd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      ctrl_q.div <= DIV_RST;
      wd_q       <= '0;
    end else if (we_i) begin
      if (addr_i == A_CTRL)  ctrl_q <= new_c;
      if (addr_i == A_WDATA) wd_q   <= wdata_i[DATA_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o = ctrl_q;
      A_WDATA: rdata_o = {{(REG_W-DATA_W){1'b0}}, wd_q};
      A_STAT:  rdata_o = {{(REG_W-DATA_W-1){1'b0}}, busy_i, rd_data_i};
      default: rdata_o = '0;
    endcase
  end

  a_r3_launch_needs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |=> ctrl_q.load);
endmodule

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv
  import mdio_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q, hit;

  assign hit    = en_i && (cnt_q >= div_i);
  assign rise_o = hit & ~mdc_q;
  assign fall_o = hit & mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (hit) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r6_mdc_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !mdc_o);
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic              srst_i,
  input  hdr_t              hdr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              mdio_o,
  output logic              oe_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(FRAME_LEN - DATA_W);
  localparam logic [IDX_W-1:0] REL_IDX  = IDX_W'(FRAME_LEN - DATA_W - 1);

  logic [FRAME_LEN-1:0] sreg_q;
  logic [IDX_W-1:0]     idx_q;
  logic [DATA_W-1:0]    rd_q;
  logic                 busy_q, is_rd_q;

  assign busy_o    = busy_q;
  assign mdio_o    = sreg_q[FRAME_LEN-1];
  assign oe_o      = busy_q && !(is_rd_q && idx_q >= REL_IDX);
  assign rd_data_o = rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q  <= '0;
      idx_q   <= '0;
      rd_q    <= '0;
      busy_q  <= 1'b0;
      is_rd_q <= 1'b0;
    end else if (srst_i) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (launch_i) begin
      busy_q  <= 1'b1;
      idx_q   <= '0;
      is_rd_q <= (hdr_i.op == OP_RD);
      sreg_q  <= {{PRE_LEN{1'b1}}, hdr_i, wdata_i};
    end else if (busy_q) begin
      if (rise_i && is_rd_q && idx_q >= DATA_IDX)
        rd_q <= {rd_q[DATA_W-2:0], mdio_i};
      if (fall_i) begin
        if (idx_q == LAST_IDX) begin
          busy_q <= 1'b0;
        end else begin
          idx_q  <= idx_q + 1'b1;
          sreg_q <= {sreg_q[FRAME_LEN-2:0], 1'b0};
        end
      end
    end
  end

  a_r4_no_launch_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |-> !busy_q);
  a_r2_busy_on_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i && !srst_i |=> busy_q);
  a_r10_srst_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> !busy_q);
  a_r9_done_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(srst_i) || $past(fall_i));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter logic [DIV_W-1:0] DIV_RST = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             mdc_o,
  output logic             mdio_o,
  output logic             mdio_oe_o,
  input  logic             mdio_i
);
  logic [DIV_W-1:0]  div;
  logic [DATA_W-1:0] wr_data, rd_data;
  hdr_t              hdr;
  logic              launch, srst, busy, rise, fall;

  mdio_regs #(.DIV_RST(DIV_RST)) u_regs (
    .clk_i, .rst_ni,
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .busy_i    (busy),
    .rd_data_i (rd_data),
    .div_o     (div),
    .wr_data_o (wr_data),
    .hdr_o     (hdr),
    .launch_o  (launch),
    .srst_o    (srst)
  );

  mdio_clkdiv u_clkdiv (
    .clk_i, .rst_ni,
    .en_i   (busy & ~srst),
    .div_i  (div),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame u_frame (
    .clk_i, .rst_ni,
    .launch_i  (launch),
    .srst_i    (srst),
    .hdr_i     (hdr),
    .wdata_i   (wr_data),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .busy_o    (busy),
    .mdio_o    (mdio_o),
    .oe_o      (mdio_oe_o),
    .rd_data_o (rd_data)
  );

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdc_o && !mdio_oe_o);
  a_r6_change_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && $past(busy) && !$fell(mdc_o) |-> $stable(mdio_o));
endmodule

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [25:0] reg_wdata_i = '0;
  logic [25:0] reg_rdata_o;
  logic        mdc_o, mdio_o, mdio_oe_o;
  logic        mdio_i = 1'b1;

  always #10 clk_i = ~clk_i;

  mdio_master dut_i (.*);

  int tests = 0, fails = 0, cyc = 0;
  always @(posedge clk_i) cyc++;

  // PHY model and bus monitor
  int          bitcnt = 0, per_err = 0, last_rise = 0, exp_div = 7;
  logic [63:0] seen_bits = '0, seen_oe = '0;
  logic [15:0] phy_val = '0;
  logic        mdc_prev = 1'b0;
  always @(negedge clk_i) begin
    if (mdc_o && !mdc_prev) begin
      if (bitcnt < 64) begin
        seen_bits[63-bitcnt] = mdio_o;
        seen_oe[63-bitcnt]   = mdio_oe_o;
      end
      if (bitcnt > 0 && (cyc - last_rise) != 2*(exp_div+1)) per_err++;
      last_rise = cyc;
      bitcnt++;
    end
    mdc_prev = mdc_o;
    mdio_i = (bitcnt >= 48 && bitcnt < 64) ? phy_val[63-bitcnt] : 1'b1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [25:0] mk_ctrl(input logic [4:0] phy, input logic [4:0] ra,
      input logic [1:0] op, input logic [7:0] div, input logic load, input logic srst);
    return {srst, load, div, 2'b10, 2'b01, op, ra, phy};
  endfunction

  function automatic logic [63:0] exp_frame(input logic [4:0] phy, input logic [4:0] ra,
      input logic [1:0] op, input logic [15:0] data);
    return {32'hFFFF_FFFF, 2'b01, op, phy, ra, 2'b10, data};
  endfunction

  task automatic reg_write(input logic [1:0] a, input logic [25:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [25:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic start_frame(input logic [4:0] phy, input logic [4:0] ra, input logic [1:0] op,
      input logic [15:0] data, input logic [7:0] div, input logic [15:0] resp);
    logic [25:0] s;
    exp_div = div; phy_val = resp;
    reg_write(2'd1, {10'd0, data});
    reg_write(2'd0, mk_ctrl(phy, ra, op, div, 1'b0, 1'b0));
    reg_read(2'd2, s);
    chk("R2 busy low without edge", {63'd0, s[16]}, 64'd0);
    #2 bitcnt = 0; per_err = 0;
    reg_write(2'd0, mk_ctrl(phy, ra, op, div, 1'b1, 1'b0));
    reg_read(2'd2, s);
    chk("R2 busy after launch", {63'd0, s[16]}, 64'd1);
  endtask

  task automatic finish_frame(input logic [4:0] phy, input logic [4:0] ra, input logic [1:0] op,
      input logic [15:0] data, input logic [15:0] resp);
    logic [25:0] s;
    logic [63:0] ef;
    int n = 0;
    reg_read(2'd2, s);
    while (s[16] && n < 20000) begin
      @(negedge clk_i); reg_read(2'd2, s); n++;
    end
    ef = exp_frame(phy, ra, op, data);
    chk("R9 rising edges at busy fall", 64'(bitcnt), 64'd64);
    chk("R6 mdc period", 64'(per_err), 64'd0);
    if (op == 2'b10) begin
      chk("R5 read frame bits", {17'd0, seen_bits[63:17]}, {17'd0, ef[63:17]});
      chk("R7 read release", seen_oe, {{47{1'b1}}, 17'd0});
      chk("R8 read data", {48'd0, s[15:0]}, {48'd0, resp});
    end else begin
      chk("R5 write frame bits", seen_bits, ef);
      chk("R7 write drive", seen_oe, {64{1'b1}});
    end
  endtask

  initial begin : watchdog
    wait (cyc >= 150000);
    tests++; fails++;
    $display("FAIL R9 watchdog act=%0d exp<150000", cyc);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [25:0] s;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    reg_read(2'd0, s); chk("R1 ctrl reset", {38'd0, s}, 64'h0070000);
    reg_read(2'd1, s); chk("R1 wdata reset", {38'd0, s}, 64'd0);
    reg_read(2'd2, s); chk("R1 status reset", {38'd0, s}, 64'd0);
    chk("R1 pins idle", {62'd0, mdc_o, mdio_oe_o}, 64'd0);

    // directed write and read
    start_frame(5'h1F, 5'h00, 2'b01, 16'hA5C3, 8'd7, 16'h0000);
    finish_frame(5'h1F, 5'h00, 2'b01, 16'hA5C3, 16'h0000);
    start_frame(5'h00, 5'h1F, 2'b10, 16'h0000, 8'd0, 16'h8001);
    finish_frame(5'h00, 5'h1F, 2'b10, 16'h0000, 16'h8001);

    // R3: level held high starts nothing
    reg_write(2'd0, mk_ctrl(5'h00, 5'h1F, 2'b10, 8'd0, 1'b1, 1'b0));
    reg_read(2'd2, s);
    chk("R3 busy on held load", {63'd0, s[16]}, 64'd0);
    repeat (30) @(negedge clk_i);
    chk("R3 no mdc edges", 64'(bitcnt), 64'd64);

    // R4: edge while busy ignored
    start_frame(5'h0A, 5'h15, 2'b01, 16'h1234, 8'd2, 16'h0);
    repeat (100) @(negedge clk_i);
    reg_write(2'd0, mk_ctrl(5'h0A, 5'h15, 2'b01, 8'd2, 1'b0, 1'b0));
    reg_write(2'd0, mk_ctrl(5'h0A, 5'h15, 2'b01, 8'd2, 1'b1, 1'b0));
    finish_frame(5'h0A, 5'h15, 2'b01, 16'h1234, 16'h0);
    repeat (40) @(negedge clk_i);
    reg_read(2'd2, s);
    chk("R4 no second frame busy", {63'd0, s[16]}, 64'd0);
    chk("R4 no second frame edges", 64'(bitcnt), 64'd64);

    // R10: soft reset mid-frame
    start_frame(5'h03, 5'h04, 2'b10, 16'h0, 8'd3, 16'hBEEF);
    repeat (100) @(negedge clk_i);
    reg_write(2'd0, mk_ctrl(5'h03, 5'h04, 2'b10, 8'd3, 1'b0, 1'b1));
    reg_read(2'd2, s);
    chk("R10 busy cleared", {63'd0, s[16]}, 64'd0);
    chk("R10 pins idle", {62'd0, mdc_o, mdio_oe_o}, 64'd0);
    reg_write(2'd0, mk_ctrl(5'h03, 5'h04, 2'b10, 8'd3, 1'b1, 1'b1));
    reg_read(2'd2, s);
    chk("R10 no launch in reset", {63'd0, s[16]}, 64'd0);
    reg_write(2'd0, mk_ctrl(5'h03, 5'h04, 2'b10, 8'd3, 1'b0, 1'b0));
    reg_read(2'd0, s);
    chk("R10 divider kept", {56'd0, s[23:16]}, 64'd3);
    start_frame(5'h03, 5'h04, 2'b10, 16'h0, 8'd3, 16'hBEEF);
    finish_frame(5'h03, 5'h04, 2'b10, 16'h0, 16'hBEEF);

    // random frames
    for (int i = 0; i < 12; i++) begin
      logic [4:0]  phy = 5'($urandom);
      logic [4:0]  ra  = 5'($urandom);
      logic [1:0]  op  = ($urandom % 2) ? 2'b10 : 2'b01;
      logic [15:0] d   = 16'($urandom);
      logic [15:0] r   = 16'($urandom);
      logic [7:0]  dv  = 8'($urandom % 6);
      start_frame(phy, ra, op, d, dv, r);
      finish_frame(phy, ra, op, d, r);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule